// File: doc/BRIEF.md
# Snoop Window Coherency Decoder

This block decides, for each bus master transaction, whether the processor cache must snoop it. Software programs one 32-bit window register with a base address, a window size and a polarity bit. When a master begins an address tenure, the block compares the tenure address against the window. It then drives an active-low global-coherency signal that stays valid for the whole tenure.

The polarity bit picks the snooped region: either the inside of the window or everything outside it. A separate snoop-enable input comes from the arbiter configuration. When that input is low, every transaction is forced to non-snooped, whatever the window says. Masters whose traffic does not need coherence can be kept out of the snooped region, which spares the cache snoop work.

Top module: `snoop_window_decoder`

## Requirements
- R1: While reset is asserted and just after it is released, `reg_rdata_o` reads 0 and `global_n_o` is 1 (negated).
- R2: A write with `reg_wr_i` high stores the window fields and is visible on `reg_rdata_o` from the next cycle. The fields are: base page in bits [31:12], policy in bit 7 and size code in bits [4:0].
- R3: Bits [11:8] and [6:5] always read 0, and writing 1s to them has no effect.
- R4: The window covers 2^(size+12) bytes, starting at the base with its low address bits ignored. For a size code of 20 or more, the window covers the whole 32-bit address space.
- R5: With policy 0 and snoop enable high, an address inside the window gives `global_n_o` = 0 and an address outside it gives 1.
- R6: With policy 1 and snoop enable high, an address outside the window gives `global_n_o` = 0 and an address inside it gives 1.
- R7: When `snoop_en_i` is 0 at a tenure start, `global_n_o` becomes 1 regardless of address and policy.
- R8: `global_n_o` changes only in the cycle after a `tenure_start_i` strobe. It holds its value through later changes of address, register or enable until the next strobe.
- R9: If a register write and a tenure start occur in the same cycle, the decision uses the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Window register write strobe |
| reg_wdata_i | input | 32 | Window register write data |
| reg_rdata_o | output | 32 | Window register read data |
| snoop_en_i | input | 1 | Global snoop enable from configuration |
| tenure_start_i | input | 1 | Start of a master address tenure |
| tenure_addr_i | input | 32 | Address of the starting tenure |
| global_n_o | output | 1 | Global coherency, active low, held per tenure |

## Verification
The bench checks addresses one byte inside and one byte outside the window, for small, mid-range and saturated size codes. A wrong mask width would misjudge exactly these boundary addresses. It flips the policy bit on the same addresses to catch inverted polarity, and it drops snoop enable to catch a gate that leaks the decoded value. It changes the address, the register and the enable between strobes, and it writes the register in the same cycle as a strobe. A design that decodes combinationally, or that reads the freshly written value, would show the wrong signal in those cycles.

// File: rtl/snoop_win_pkg.sv
package snoop_win_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_W   = 12;
  localparam int SIZE_W   = 5;
  localparam int RSVD_HI  = 4;
  localparam int RSVD_LO  = 2;
  localparam int BASE_W   = ADDR_W - PAGE_W;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [RSVD_HI-1:0] rsvd_hi;
    logic               policy;
    logic [RSVD_LO-1:0] rsvd_lo;
    logic [SIZE_W-1:0]  size;
  } win_cfg_t;

  localparam logic [ADDR_W-1:0] WR_MASK =
    {{BASE_W{1'b1}}, {RSVD_HI{1'b0}}, 1'b1, {RSVD_LO{1'b0}}, {SIZE_W{1'b1}}};
endpackage

// File: rtl/snoop_win_reg.sv
module snoop_win_reg
  import snoop_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output win_cfg_t          cfg_o
);
  win_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= win_cfg_t'(wdata_i & WR_MASK);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/snoop_win_match.sv
module snoop_win_match
  import snoop_win_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [BASE_W-1:0] bit_ok;

  // page bit i is compared only when it lies above the window size
  for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
    assign bit_ok[i] = (int'(cfg_i.size) > i) || (addr_i[PAGE_W+i] == cfg_i.base[i]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/snoop_win_gate.sv
module snoop_win_gate (
  input  logic hit_i,
  input  logic policy_i,
  input  logic en_i,
  output logic snoop_o
);
  always_comb snoop_o = en_i & (hit_i ^ policy_i);
endmodule

// File: rtl/snoop_window_decoder.sv
module snoop_window_decoder
  import snoop_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              snoop_en_i,
  input  logic              tenure_start_i,
  input  logic [ADDR_W-1:0] tenure_addr_i,
  output logic              global_n_o
);
  win_cfg_t cfg;
  logic     hit;
  logic     snoop;
  logic     global_n_q;

  snoop_win_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  snoop_win_match u_match (
    .cfg_i  (cfg),
    .addr_i (tenure_addr_i),
    .hit_o  (hit)
  );

  snoop_win_gate u_gate (
    .hit_i    (hit),
    .policy_i (cfg.policy),
    .en_i     (snoop_en_i),
    .snoop_o  (snoop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             global_n_q <= 1'b1;
    else if (tenure_start_i) global_n_q <= ~snoop;
  end

  assign global_n_o  = global_n_q;
  assign reg_rdata_o = cfg;
endmodule

// File: rtl/snoop_window_decoder_chk.sv
module snoop_window_decoder_chk
  import snoop_win_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic [ADDR_W-1:0] reg_rdata_o,
  input logic              snoop_en_i,
  input logic              tenure_start_i,
  input logic [ADDR_W-1:0] tenure_addr_i,
  input logic              global_n_o
);
  logic exact_hit;
  assign exact_hit = tenure_start_i && snoop_en_i && (reg_rdata_o[SIZE_W-1:0] == '0)
                     && (tenure_addr_i[ADDR_W-1:PAGE_W] == reg_rdata_o[ADDR_W-1:PAGE_W]);

  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> reg_rdata_o == ($past(reg_wdata_i) & WR_MASK));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~WR_MASK) == '0);

  // R5
  inside_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exact_hit && !reg_rdata_o[7] && !reg_wr_i |=> !global_n_o);

  // R6
  inside_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exact_hit && reg_rdata_o[7] |=> global_n_o);

  // R7
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tenure_start_i && !snoop_en_i |=> global_n_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tenure_start_i |=> $stable(global_n_o));
endmodule

bind snoop_window_decoder snoop_window_decoder_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .snoop_en_i     (snoop_en_i),
  .tenure_start_i (tenure_start_i),
  .tenure_addr_i  (tenure_addr_i),
  .global_n_o     (global_n_o)
);

// File: tb/snoop_window_decoder_tb_top.sv
`timescale 1ns/1ps
module snoop_window_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        snoop_en_i = 1'b0;
  logic        tenure_start_i = 1'b0;
  logic [31:0] tenure_addr_i = '0;
  logic        global_n_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] reg_m = '0;
  logic        gn_m = 1'b1;

  always #2.5 clk_i = ~clk_i;

  snoop_window_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .snoop_en_i(snoop_en_i), .tenure_start_i(tenure_start_i),
    .tenure_addr_i(tenure_addr_i), .global_n_o(global_n_o)
  );

  function automatic bit in_win(logic [31:0] r, logic [31:0] a);
    int unsigned sz = r[4:0];
    longint unsigned span;
    if (sz >= 20) return 1'b1;
    span = 64'd1 << (sz + 12);
    return (longint'(a) / span) == (longint'(r & 32'hFFFF_F000) / span);
  endfunction

  task automatic compare(input string req);
    compared++;
    if (reg_rdata_o !== reg_m) begin
      mismatched++;
      $display("FAIL %s rdata actual=%h expected=%h", req, reg_rdata_o, reg_m);
    end
    compared++;
    if (global_n_o !== gn_m) begin
      mismatched++;
      $display("FAIL %s global_n actual=%b expected=%b", req, global_n_o, gn_m);
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input bit ts,
                      input logic [31:0] a, input bit en, input string req);
    reg_wr_i = wr; reg_wdata_i = wd; tenure_start_i = ts;
    tenure_addr_i = a; snoop_en_i = en;
    @(posedge clk_i);
    #1;
    if (ts) gn_m = !(en && (in_win(reg_m, a) ^ reg_m[7]));
    if (wr) reg_m = wd & 32'hFFFF_F09F;
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R2 / R3 field storage, reserved bits dropped
    step(1, 32'hFFFF_FFFF, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 1, "R3");
    step(1, 32'hA5A5_A0F4, 0, 0, 1, "R2");
    step(1, 32'h0000_0F60, 0, 0, 1, "R3");

    // R5 policy 0, 4 KB window
    step(1, 32'h1234_5000, 0, 0, 1, "R2");
    step(0, 0, 1, 32'h1234_5ABC, 1, "R5");
    step(0, 0, 1, 32'h1234_6000, 1, "R5");
    step(0, 0, 1, 32'h1234_4FFF, 1, "R5");
    step(0, 0, 1, 32'h1234_5000, 1, "R5");

    // R4 64 KB window boundaries
    step(1, 32'h1234_0004, 0, 0, 1, "R4");
    step(0, 0, 1, 32'h1234_FFFF, 1, "R4");
    step(0, 0, 1, 32'h1235_0000, 1, "R4");
    step(0, 0, 1, 32'h1233_FFFF, 1, "R4");
    // saturated sizes
    step(1, 32'h0000_0014, 0, 0, 1, "R4");
    step(0, 0, 1, 32'hDEAD_BEEF, 1, "R4");
    step(1, 32'h8000_001F, 0, 0, 1, "R4");
    step(0, 0, 1, 32'h0000_0000, 1, "R4");
    step(1, 32'h8000_0013, 0, 0, 1, "R4");
    step(0, 0, 1, 32'h7FFF_FFFF, 1, "R4");
    step(0, 0, 1, 32'h8000_0000, 1, "R4");

    // R6 policy 1
    step(1, 32'h1234_0084, 0, 0, 1, "R6");
    step(0, 0, 1, 32'h1234_8000, 1, "R6");
    step(0, 0, 1, 32'h1235_0000, 1, "R6");
    step(0, 0, 1, 32'h0000_0000, 1, "R6");

    // R7 enable gating under both policies
    step(0, 0, 1, 32'h0000_0000, 0, "R7");
    step(1, 32'h1234_0004, 0, 0, 1, "R7");
    step(0, 0, 1, 32'h1234_8000, 1, "R7");
    step(0, 0, 1, 32'h1234_8000, 0, "R7");

    // R8 hold between strobes
    step(0, 0, 1, 32'h1234_8000, 1, "R8");
    step(0, 0, 0, 32'hFFFF_0000, 0, "R8");
    step(1, 32'h0000_0080, 0, 32'h0, 1, "R8");
    step(0, 0, 0, 32'h1234_8000, 1, "R8");
    step(0, 0, 0, 32'h1234_8000, 0, "R8");

    // R9 write and strobe together: old register decides
    step(1, 32'h1234_0004, 0, 0, 1, "R9");
    step(1, 32'h1234_0084, 1, 32'h1234_1000, 1, "R9");
    step(1, 32'h1234_0004, 1, 32'h1234_1000, 1, "R9");
    step(0, 0, 1, 32'h1234_1000, 1, "R9");

    // mixed traffic, addresses biased toward the window
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] wd;
      bit wr, ts, en;
      wr = ($urandom % 5) == 0;
      ts = ($urandom % 3) != 0;
      en = ($urandom % 6) != 0;
      wd = $urandom;
      a  = $urandom;
      if ($urandom % 2) a = (reg_m & 32'hFFFF_F000) ^ (32'h1 << ($urandom % 32));
      step(wr, wd, ts, a, en, "R4");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule